// File: doc/BRIEF.md
# Low-Power Wake-Up Controller

This block decides when a chip parked in a low-power state (power-down or sleep) may run again. Software parks the chip with a one-cycle request. While parked, the controller watches several pins. Any of the following starts a wake-up:

- a change in card presence, in either direction;
- an overcurrent flag on the card supply;
- a high level on either of two hard-reset pins;
- a falling edge on the serial receive line;
- a falling edge on the active-low external interrupt line.

The two edge sources only count when their enable bits allow them. The serial-line source also needs the interrupt path to be open.

A wake condition does not release the chip at once. The controller first raises a wake request to the clock logic. It holds that request for a fixed settling window, 1536 clocks by default, so the restarting oscillator can settle. Only after that window does it report that the chip is running. All pins are raw asynchronous levels. Each one passes through a synchronizer chain before it is examined.

The card level is sampled at the moment the chip is parked. Presence is then judged against that sampled reference. Wake conditions that arrive during the settling window are absorbed. While running, pin activity is ignored. A park request always wins: it cancels a wake-up in progress, and it also wins over a wake condition that appears in the same cycle.

Top module: `lp_wake_ctrl`

## Requirements
- R1: After reset the block is in run mode: `run_ready` is 1 and `wake_req` is 0.
- R2: A `sleep_req` pulse in run mode parks the block: from the next cycle both `run_ready` and `wake_req` are 0. In the same cycle the synchronized card level is stored as the presence reference.
- R3: While parked, a synchronized `card_present` level that differs from the stored reference starts a wake-up. This applies to insertion and removal alike.
- R4: While parked, `supply_ovc` high starts a wake-up, whatever the enable bits are.
- R5: While parked, a high level on `hard_rst_a` or on `hard_rst_b` starts a wake-up, whatever the enable bits are.
- R6: While parked, a 1-to-0 transition of `rx_line` starts a wake-up only when `rx_wake_en`, `irq_wake_en` and `irq_ctrl_en` are all 1.
- R7: While parked, a 1-to-0 transition of `ext_irq_n` starts a wake-up only when both `irq_wake_en` and `irq_ctrl_en` are 1.
- R8: With `SYNC_STAGES` = S, a pin change applied between clock edges shows up on `wake_req` after the (S+1)-th rising edge that follows it, and not earlier.
- R9: `wake_req` stays 1 for exactly `SETTLE_CYCLES` cycles. Then `wake_req` drops and `run_ready` rises on the same edge. The two outputs are never 1 together.
- R10: Wake conditions that arise while `wake_req` is 1 neither restart nor shorten the settling window.
- R11: In run mode, activity on any wake pin leaves `run_ready` at 1 and `wake_req` at 0.
- R12: A `sleep_req` during the settling window, or in the same cycle as a fresh wake condition while parked, leaves the block parked. `wake_req` is 0 from the next cycle, and the lost wake condition is not acted on later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | One-cycle request to enter or re-enter low power |
| card_present | input | 1 | Raw card presence level |
| supply_ovc | input | 1 | Raw card supply overcurrent flag, active high |
| hard_rst_a | input | 1 | Raw first hard-reset pin, active high |
| hard_rst_b | input | 1 | Raw second hard-reset pin, active high |
| rx_line | input | 1 | Raw serial receive line, idle high |
| ext_irq_n | input | 1 | Raw external interrupt line, active low |
| rx_wake_en | input | 1 | Allows a receive-line falling edge to wake |
| irq_wake_en | input | 1 | Allows an interrupt-line falling edge to wake |
| irq_ctrl_en | input | 1 | Interrupt enabled in the controller core |
| wake_req | output | 1 | Oscillator restart in progress (settling window) |
| run_ready | output | 1 | Chip is in run mode |

## Verification
The interesting overlap is a park request that lands in the same cycle as a fresh wake condition. To provoke it, the bench drops the receive line with all enables set. It then times `sleep_req` so that the park request and the synchronized falling edge reach the controller on the same rising edge. The bench expects the park request to win: `wake_req` must stay 0 both then and for longer than a full settling window afterwards, because the edge is a one-cycle event and must not be replayed. A second overlap is also checked: an overcurrent flag and a hard-reset pin fire in the middle of the window, and `run_ready` must still rise on the edge computed from the first wake condition.

// File: rtl/lp_wake_pkg.sv
package lp_wake_pkg;

   // Power-mode encoding of the controller state register
   typedef enum logic [1:0] {
      PM_RUN    = 2'd0,
      PM_LOW    = 2'd1,
      PM_SETTLE = 2'd2
   } pm_state_t;

   // Bit positions of the raw pin vector fed to the synchronizer bank
   localparam int SRC_CARD = 0;
   localparam int SRC_OVC  = 1;
   localparam int SRC_RSTA = 2;
   localparam int SRC_RSTB = 3;
   localparam int SRC_RX   = 4;
   localparam int SRC_IRQ  = 5;
   localparam int NUM_SRC  = 6;

   // Level-sensitive sources occupy the low part of the vector
   localparam int NUM_LVL  = 4;

   // Edge-sensitive sources, in edge-detector lane order
   localparam int EDGE_RX  = 0;
   localparam int EDGE_IRQ = 1;
   localparam int NUM_EDGE = NUM_SRC - NUM_LVL;

endpackage

// File: rtl/lp_wake_sync.sv
// Bank of multi-flop synchronizers, one chain per input bit.
module lp_wake_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("lp_wake_sync: WIDTH must be at least 1");
      end
      if (STAGES < 2) begin : g_bad_stages
         $error("lp_wake_sync: STAGES must be at least 2");
      end
   endgenerate

   genvar b;
   generate
      for (b = 0; b < WIDTH; b++) begin : g_lane
         logic [STAGES-1:0] chain_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q <= {chain_q[STAGES-2:0], async_in[b]};
            end
         end

         assign sync_out[b] = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/lp_wake_edge.sv
// Per-lane edge detector; FALL_MASK picks falling (1) or rising (0) per lane.
module lp_wake_edge #(
   parameter int               WIDTH     = 1,
   parameter logic [WIDTH-1:0] FALL_MASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   output logic [WIDTH-1:0] hit
);

   logic [WIDTH-1:0] prev_q;

   // Previous level resets low, so a lane idling high after reset
   // never reports a spurious falling edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
      end else begin
         prev_q <= level;
      end
   end

   genvar b;
   generate
      for (b = 0; b < WIDTH; b++) begin : g_lane
         if (FALL_MASK[b]) begin : g_fall
            assign hit[b] = prev_q[b] & ~level[b];
         end else begin : g_rise
            assign hit[b] = ~prev_q[b] & level[b];
         end
      end
   endgenerate

endmodule

// File: rtl/lp_wake_qualify.sv
// Combines synchronized levels, detected edges and enable bits
// into a single wake condition.
module lp_wake_qualify
   import lp_wake_pkg::*;
(
   input  logic                lowpwr,
   input  logic [NUM_LVL-1:0]  lvl,
   input  logic [NUM_EDGE-1:0] fall,
   input  logic                card_ref,
   input  logic                rx_wake_en,
   input  logic                irq_wake_en,
   input  logic                irq_ctrl_en,
   output logic                any_wake
);

   logic [NUM_SRC-1:0] src_hit;
   logic               irq_path;

   always_comb begin
      irq_path          = irq_wake_en & irq_ctrl_en;
      src_hit           = '0;
      src_hit[SRC_CARD] = lvl[SRC_CARD] ^ card_ref;
      src_hit[SRC_OVC]  = lvl[SRC_OVC];
      src_hit[SRC_RSTA] = lvl[SRC_RSTA];
      src_hit[SRC_RSTB] = lvl[SRC_RSTB];
      // the receive line wakes through the interrupt path only
      src_hit[SRC_RX]   = fall[EDGE_RX] & rx_wake_en & irq_path;
      src_hit[SRC_IRQ]  = fall[EDGE_IRQ] & irq_path;
      any_wake          = lowpwr & (|src_hit);
   end

endmodule

// File: rtl/lp_wake_timer.sv
// Oscillator settling window: loads on wake entry, counts down to zero.
module lp_wake_timer #(
   parameter int CYCLES = 1536
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);

   localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
   localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES - 1);

   generate
      if (CYCLES < 2) begin : g_bad_cycles
         $error("lp_wake_timer: CYCLES must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= LOAD_VAL;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/lp_wake_ctrl.sv
// Low-power wake-up controller: top level with the power-mode sequencer.
module lp_wake_ctrl
   import lp_wake_pkg::*;
#(
   parameter int SETTLE_CYCLES = 1536,
   parameter int SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_req,
   input  logic card_present,
   input  logic supply_ovc,
   input  logic hard_rst_a,
   input  logic hard_rst_b,
   input  logic rx_line,
   input  logic ext_irq_n,
   input  logic rx_wake_en,
   input  logic irq_wake_en,
   input  logic irq_ctrl_en,
   output logic wake_req,
   output logic run_ready
);

   generate
      if (SETTLE_CYCLES < 2) begin : g_bad_settle
         $error("lp_wake_ctrl: SETTLE_CYCLES must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("lp_wake_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NUM_SRC-1:0]  pin_raw;
   logic [NUM_SRC-1:0]  pin_sync;
   logic [NUM_EDGE-1:0] edge_fall;
   logic                card_ref_q;
   logic                any_wake;
   logic                settle_done;
   logic                timer_load;
   pm_state_t           state_q;
   pm_state_t           state_d;

   always_comb begin
      pin_raw           = '0;
      pin_raw[SRC_CARD] = card_present;
      pin_raw[SRC_OVC]  = supply_ovc;
      pin_raw[SRC_RSTA] = hard_rst_a;
      pin_raw[SRC_RSTB] = hard_rst_b;
      pin_raw[SRC_RX]   = rx_line;
      pin_raw[SRC_IRQ]  = ext_irq_n;
   end

   lp_wake_sync #(
      .WIDTH  (NUM_SRC),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_raw),
      .sync_out (pin_sync)
   );

   lp_wake_edge #(
      .WIDTH     (NUM_EDGE),
      .FALL_MASK ({NUM_EDGE{1'b1}})
   ) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .level (pin_sync[NUM_SRC-1:NUM_LVL]),
      .hit   (edge_fall)
   );

   lp_wake_qualify u_qual (
      .lowpwr      (state_q == PM_LOW),
      .lvl         (pin_sync[NUM_LVL-1:0]),
      .fall        (edge_fall),
      .card_ref    (card_ref_q),
      .rx_wake_en  (rx_wake_en),
      .irq_wake_en (irq_wake_en),
      .irq_ctrl_en (irq_ctrl_en),
      .any_wake    (any_wake)
   );

   // The card reference is taken on every accepted park request.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         card_ref_q <= 1'b0;
      end else if (sleep_req) begin
         card_ref_q <= pin_sync[SRC_CARD];
      end
   end

   // Park requests take priority over everything else.
   always_comb begin
      state_d = state_q;
      case (state_q)
         PM_RUN: begin
            if (sleep_req) state_d = PM_LOW;
         end
         PM_LOW: begin
            if (sleep_req)     state_d = PM_LOW;
            else if (any_wake) state_d = PM_SETTLE;
         end
         PM_SETTLE: begin
            if (sleep_req)        state_d = PM_LOW;
            else if (settle_done) state_d = PM_RUN;
         end
         default: state_d = PM_RUN;
      endcase
   end

   assign timer_load = (state_q == PM_LOW) & (state_d == PM_SETTLE);

   lp_wake_timer #(
      .CYCLES (SETTLE_CYCLES)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (timer_load),
      .expired (settle_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PM_RUN;
      end else begin
         state_q <= state_d;
      end
   end

   assign wake_req  = (state_q == PM_SETTLE);
   assign run_ready = (state_q == PM_RUN);

endmodule

// File: rtl/lp_wake_ctrl_chk.sv
// Port-level checker for lp_wake_ctrl, attached by bind below.
module lp_wake_ctrl_chk #(
   parameter int SETTLE_CYCLES = 1536
) (
   input logic clk,
   input logic rst_n,
   input logic sleep_req,
   input logic wake_req,
   input logic run_ready
);

   localparam int CW = $clog2(SETTLE_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);
   localparam logic [CW-1:0] SAT  = CW'(SETTLE_CYCLES);

   // consecutive cycles wake_req has already been high before this one
   logic [CW-1:0] win_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt <= '0;
      end else if (!wake_req) begin
         win_cnt <= '0;
      end else if (win_cnt != SAT) begin
         win_cnt <= win_cnt + 1'b1;
      end
   end

   // R9
   outputs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wake_req && run_ready));

   // R9
   settle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_req && !sleep_req && win_cnt == LAST) |=> (run_ready && !wake_req));

   // R10
   settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_req && !sleep_req && win_cnt < LAST) |=> (wake_req && !run_ready));

   // R11
   run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_ready && !sleep_req) |=> run_ready);

   // R11
   no_wake_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_ready |=> !wake_req);

   // R2
   sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_req |=> (!run_ready && !wake_req));

endmodule

bind lp_wake_ctrl lp_wake_ctrl_chk #(
   .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sleep_req (sleep_req),
   .wake_req  (wake_req),
   .run_ready (run_ready)
);

// File: tb/lp_wake_ctrl_tb.sv
module lp_wake_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 12;
   localparam int SYNC       = 2;
   localparam int LAT        = SYNC + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_req = 1'b0;
   logic card_present = 1'b0;
   logic supply_ovc = 1'b0;
   logic hard_rst_a = 1'b0;
   logic hard_rst_b = 1'b0;
   logic rx_line = 1'b1;
   logic ext_irq_n = 1'b1;
   logic rx_wake_en = 1'b0;
   logic irq_wake_en = 1'b0;
   logic irq_ctrl_en = 1'b0;
   logic wake_req;
   logic run_ready;

   int n_vec = 0;
   int n_mis = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   lp_wake_ctrl #(
      .SETTLE_CYCLES (SETTLE),
      .SYNC_STAGES   (SYNC)
   ) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .sleep_req    (sleep_req),
      .card_present (card_present),
      .supply_ovc   (supply_ovc),
      .hard_rst_a   (hard_rst_a),
      .hard_rst_b   (hard_rst_b),
      .rx_line      (rx_line),
      .ext_irq_n    (ext_irq_n),
      .rx_wake_en   (rx_wake_en),
      .irq_wake_en  (irq_wake_en),
      .irq_ctrl_en  (irq_ctrl_en),
      .wake_req     (wake_req),
      .run_ready    (run_ready)
   );

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      n_vec++;
      if (act !== exp) begin
         n_mis++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic idle_pins();
      supply_ovc = 1'b0;
      hard_rst_a = 1'b0;
      hard_rst_b = 1'b0;
      rx_line    = 1'b1;
      ext_irq_n  = 1'b1;
   endtask

   task automatic park();
      sleep_req = 1'b1;
      tick(1);
      sleep_req = 1'b0;
   endtask

   function automatic string src_tag(input int src);
      case (src)
         0:       return "R3";
         1:       return "R4";
         2, 3:    return "R5";
         4:       return "R6";
         default: return "R7";
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_mis++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_mis);
      $finish;
   end

   initial begin
      // ---- reset state: R1
      tick(3);
      rst_n = 1'b1;
      tick(1);
      chk("R1", "run_ready", run_ready, 1'b1);
      chk("R1", "wake_req", wake_req, 1'b0);

      // ---- pin activity in run mode is ignored: R11
      rx_wake_en = 1'b1; irq_wake_en = 1'b1; irq_ctrl_en = 1'b1;
      supply_ovc = 1'b1; hard_rst_a = 1'b1; rx_line = 1'b0;
      ext_irq_n = 1'b0; card_present = 1'b1;
      for (int i = 0; i < LAT + 3; i++) begin
         tick(1);
         chk("R11", "run_ready", run_ready, 1'b1);
         chk("R11", "wake_req", wake_req, 1'b0);
      end
      idle_pins();
      tick(LAT + 1);

      // ---- sweep: every enable combination against every source
      for (int en = 0; en < 8; en++) begin
         for (int src = 0; src < 6; src++) begin
            logic exp;
            rx_wake_en  = en[0];
            irq_wake_en = en[1];
            irq_ctrl_en = en[2];
            park();
            chk("R2", "run_ready", run_ready, 1'b0);
            chk("R2", "wake_req", wake_req, 1'b0);
            tick(2);
            case (src)
               0:       card_present = ~card_present;
               1:       supply_ovc = 1'b1;
               2:       hard_rst_a = 1'b1;
               3:       hard_rst_b = 1'b1;
               4:       rx_line = 1'b0;
               default: ext_irq_n = 1'b0;
            endcase
            if (src < 4)       exp = 1'b1;
            else if (src == 4) exp = (en == 7);
            else               exp = en[1] & en[2];
            tick(LAT - 1);
            chk("R8", "wake_req early", wake_req, 1'b0);
            tick(1);
            chk(src_tag(src), "wake_req", wake_req, exp);
            if (exp) begin
               tick(SETTLE - 1);
               chk("R9", "wake_req last", wake_req, 1'b1);
               chk("R9", "run_ready last", run_ready, 1'b0);
               tick(1);
               chk("R9", "run_ready end", run_ready, 1'b1);
               chk("R9", "wake_req end", wake_req, 1'b0);
            end else begin
               tick(SETTLE);
               chk(src_tag(src), "masked run_ready", run_ready, 1'b0);
               chk(src_tag(src), "masked wake_req", wake_req, 1'b0);
            end
            idle_pins();
            tick(LAT + 1);
         end
      end

      // ---- events in the settling window are absorbed: R10
      rx_wake_en = 1'b1; irq_wake_en = 1'b1; irq_ctrl_en = 1'b1;
      park();
      tick(2);
      supply_ovc = 1'b1;
      tick(LAT);
      chk("R10", "wake_req start", wake_req, 1'b1);
      tick(4);
      hard_rst_a = 1'b1;
      card_present = ~card_present;
      rx_line = 1'b0;
      tick(SETTLE - 5);
      chk("R10", "wake_req last", wake_req, 1'b1);
      chk("R10", "run_ready last", run_ready, 1'b0);
      tick(1);
      chk("R10", "run_ready end", run_ready, 1'b1);
      idle_pins();
      tick(LAT + 1);

      // ---- park request during the settling window: R12
      park();
      tick(2);
      supply_ovc = 1'b1;
      tick(LAT);
      chk("R12", "wake_req before cancel", wake_req, 1'b1);
      supply_ovc = 1'b0;
      tick(LAT + 1);
      park();
      chk("R12", "wake_req cancelled", wake_req, 1'b0);
      chk("R12", "run_ready cancelled", run_ready, 1'b0);
      tick(SETTLE + 2);
      chk("R12", "wake_req stays low", wake_req, 1'b0);
      chk("R12", "run_ready stays low", run_ready, 1'b0);

      // ---- park request in the same cycle as a receive edge: R12
      park();
      rx_line = 1'b0;
      tick(2);
      park();
      chk("R12", "same-cycle wake_req", wake_req, 1'b0);
      tick(SETTLE + 2);
      chk("R12", "same-cycle wake_req later", wake_req, 1'b0);
      chk("R12", "same-cycle run_ready later", run_ready, 1'b0);
      idle_pins();
      tick(LAT + 1);

      // ---- control: same edge without the competing request wakes: R6
      rx_line = 1'b0;
      tick(LAT);
      chk("R6", "control wake_req", wake_req, 1'b1);
      idle_pins();
      tick(SETTLE + 1);
      chk("R6", "control run_ready", run_ready, 1'b1);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_mis);
      $finish;
   end

endmodule